// File: doc/BRIEF.md
# Per-Channel Transfer Address and Count Registers with Auto-Reload

This block keeps the transfer address and transfer count for four DMA channels. Each channel holds a base copy and a working (current) copy of both a 16-bit address and a 16-bit count. A host loads these registers one byte at a time over an 8-bit bus. A shared byte pointer flip-flop chooses the low or high half. Every host write to a channel register puts the same byte into the base copy and the working copy. Host reads return only the working copy.

A transfer engine outside the block sends one transfer step at a time on a valid/ready stream. Each step names a channel. The block then:
- emits the address used for that transfer, one cycle later;
- moves the working address up or down by one, as the channel's mode selects;
- decrements the working count.

When the count passes below zero the channel reaches terminal count. A channel with auto-reload copies its base values back into the working registers and keeps running. A channel without auto-reload stops, and it sets a completion bit that the host can read.

Top module: `dmaregs_top`

## Requirements
- R1: After reset all base and working registers are 0, the byte pointer points at the low byte, every channel is in increment mode without auto-reload, all completion bits are 0, and `out_valid` is 0.
- R2: A host write to a channel register uses `host_addr` = 2*ch for the address and 2*ch+1 for the count. It loads `host_wdata` into the byte named by the pointer (low byte when the pointer is 0) of both the base and the working copy. The write toggles the pointer and clears that channel's completion bit.
- R3: A host write to `host_addr` 9 returns the byte pointer to the low byte, whatever data is written.
- R4: A host read of a channel register returns, with no delay, the byte of the working copy named by the pointer, and then toggles the pointer. A read of `host_addr` 8 returns the completion bits in bits 3:0 (bit n for channel n) and does not move the pointer.
- R5: A host write to `host_addr` 8 sets a channel's mode. Data bits 1:0 give the channel, bit 4 enables auto-reload, and bit 5 selects decrement (1) or increment (0). On each accepted step the working address changes by one in the selected direction and wraps modulo 2^16.
- R6: Each accepted step decrements the working count. A step taken while the count is 0 is the terminal-count step, so a programmed count of N gives N+1 transfers.
- R7: On a terminal-count step of a channel with auto-reload, the working address and count are reloaded from the base copies, and the channel stays ready.
- R8: On a terminal-count step of a channel without auto-reload, the address and count still step (count wraps to 0xFFFF) and the completion bit is set. `step_ready` stays low for that channel until its completion bit is cleared.
- R9: A step is accepted when `step_valid` and `step_ready` are both 1. In the next cycle `out_valid` is 1, `out_addr` holds the working address from before the step, and `out_tc` is 1 only for a terminal-count step. In every other cycle `out_valid` is 0.
- R10: `step_ready` is 0 in any cycle with a host write (`host_cs` and `host_we`). A step offered then is not accepted and changes nothing.
- R11: A host write to `host_addr` 10 clears all completion bits and the byte pointer, and leaves the registers and modes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access select |
| host_we | input | 1 | Host write strobe (with host_cs) |
| host_re | input | 1 | Host read strobe (with host_cs, host_we low) |
| host_addr | input | 4 | Host register index: 0..7 channel registers, 8 mode/status, 9 pointer clear, 10 master clear |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| step_valid | input | 1 | Transfer step offered |
| step_ready | output | 1 | Step can be taken this cycle |
| step_ch | input | 2 | Channel of the offered step |
| out_valid | output | 1 | Result of an accepted step is present |
| out_addr | output | 16 | Address used by the accepted step |
| out_tc | output | 1 | Accepted step was terminal count |

Back-pressure: a step is held until `step_ready` is 1. Ready drops during host writes and for a channel that has completed. The result output cannot be stalled.

## Verification
The hardest case to reach is terminal count on a channel that was just reprogrammed. The working copy has drifted from the base copy, and a write that hits only one byte leaves mixed halves that the reload must ignore. The stimulus mostly loads small counts so that many random steps land on terminal count. It interleaves single-byte writes, pointer clears, mode flips and host writes that collide with offered steps. Directed cases cover wrap in both directions, the N+1 transfer count and the stalled step after completion.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  // control register indices inside the control half of the host map
  localparam int unsigned CTRL_MODE    = 0;
  localparam int unsigned CTRL_CLR_PTR = 1;
  localparam int unsigned CTRL_MCLR    = 2;
  // mode byte field positions
  localparam int unsigned MODE_AUTO_BIT = 4;
  localparam int unsigned MODE_DEC_BIT  = 5;

  typedef struct packed {
    logic auto_init;
    logic dec;
  } ch_mode_t;
endpackage

// File: rtl/dmaregs_host_if.sv
module dmaregs_host_if
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int CH_W   = 2,
  parameter int HA_W   = CH_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_cs,
  input  logic                       host_we,
  input  logic                       host_re,
  input  logic [HA_W-1:0]            host_addr,
  input  logic [DW-1:0]              host_wdata,
  input  logic [NUM_CH-1:0][AW-1:0]  cur_addr_vec,
  input  logic [NUM_CH-1:0][AW-1:0]  cur_cnt_vec,
  input  logic [NUM_CH-1:0]          done_vec,
  output logic                       host_wr,
  output logic [NUM_CH-1:0]          wr_addr_en,
  output logic [NUM_CH-1:0]          wr_cnt_en,
  output logic                       wr_hi,
  output logic                       mode_we,
  output logic [CH_W-1:0]            mode_ch,
  output ch_mode_t                   mode_val,
  output logic                       mclr,
  output logic [DW-1:0]              host_rdata
);
  localparam int IDX_W = HA_W - 1;

  logic            is_ctrl;
  logic [IDX_W-1:0] idx;
  logic [CH_W-1:0] reg_ch;
  logic            reg_cnt;
  logic            host_rd;
  logic            clr_ptr;
  logic            ch_ok;
  logic            byte_ptr_q;
  logic [AW-1:0]   rd_word;

  assign is_ctrl = host_addr[HA_W-1];
  assign idx     = host_addr[IDX_W-1:0];
  assign reg_ch  = idx[IDX_W-1:1];
  assign reg_cnt = idx[0];
  assign ch_ok   = (int'(reg_ch) < NUM_CH);
  assign host_wr = host_cs & host_we;
  assign host_rd = host_cs & host_re & ~host_we;

  assign mode_we  = host_wr & is_ctrl & (idx == IDX_W'(CTRL_MODE));
  assign clr_ptr  = host_wr & is_ctrl & (idx == IDX_W'(CTRL_CLR_PTR));
  assign mclr     = host_wr & is_ctrl & (idx == IDX_W'(CTRL_MCLR));
  assign mode_ch  = host_wdata[CH_W-1:0];
  assign mode_val = '{auto_init: host_wdata[MODE_AUTO_BIT], dec: host_wdata[MODE_DEC_BIT]};
  assign wr_hi    = byte_ptr_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr_dec
    assign wr_addr_en[g] = host_wr & ~is_ctrl & (reg_ch == CH_W'(g)) & ~reg_cnt;
    assign wr_cnt_en[g]  = host_wr & ~is_ctrl & (reg_ch == CH_W'(g)) &  reg_cnt;
  end

  // byte pointer: toggles on each channel-register access
  always_ff @(posedge clk) begin
    if (!rst_n)                 byte_ptr_q <= 1'b0;
    else if (clr_ptr || mclr)   byte_ptr_q <= 1'b0;
    else if ((host_wr || host_rd) && !is_ctrl) byte_ptr_q <= ~byte_ptr_q;
  end

  always_comb begin
    rd_word = '0;
    if (ch_ok) rd_word = reg_cnt ? cur_cnt_vec[reg_ch] : cur_addr_vec[reg_ch];
  end

  always_comb begin
    host_rdata = '0;
    if (!is_ctrl) host_rdata = byte_ptr_q ? rd_word[AW-1:DW] : rd_word[DW-1:0];
    else if (idx == IDX_W'(CTRL_MODE)) host_rdata = DW'(done_vec);
  end
endmodule

// File: rtl/dmaregs_chan.sv
module dmaregs_chan
  import dmaregs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr_en,
  input  logic          wr_cnt_en,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic [AW-1:0] upd_cnt,
  input  logic          set_done,
  input  logic          clr_done,
  input  logic          mode_we,
  input  ch_mode_t      mode_in,
  output logic [AW-1:0] base_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] base_cnt,
  output logic [AW-1:0] cur_cnt,
  output ch_mode_t      mode,
  output logic          done
);
  function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] old,
                                             input logic hi, input logic [DW-1:0] b);
    logic [AW-1:0] r;
    r = old;
    if (hi) r[AW-1:DW] = b;
    else    r[DW-1:0]  = b;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      done      <= 1'b0;
    end else begin
      if (wr_addr_en) begin
        base_addr <= put_byte(base_addr, wr_hi, wdata);
        cur_addr  <= put_byte(cur_addr, wr_hi, wdata);
      end else if (upd_en) begin
        cur_addr  <= upd_addr;
      end
      if (wr_cnt_en) begin
        base_cnt  <= put_byte(base_cnt, wr_hi, wdata);
        cur_cnt   <= put_byte(cur_cnt, wr_hi, wdata);
      end else if (upd_en) begin
        cur_cnt   <= upd_cnt;
      end
      if (mode_we) mode <= mode_in;
      if (clr_done)      done <= 1'b0;
      else if (set_done) done <= 1'b1;
    end
  end
endmodule

// File: rtl/dmaregs_stepper.sv
module dmaregs_stepper #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] cur_cnt,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] base_cnt,
  input  logic          dec,
  input  logic          auto_init,
  output logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] nxt_cnt,
  output logic          tc
);
  logic [AW-1:0] addr_stepped;

  assign tc           = (cur_cnt == '0);
  assign addr_stepped = dec ? (cur_addr - AW'(1)) : (cur_addr + AW'(1));

  always_comb begin
    if (tc && auto_init) begin
      nxt_addr = base_addr;
      nxt_cnt  = base_cnt;
    end else begin
      nxt_addr = addr_stepped;
      nxt_cnt  = cur_cnt - AW'(1);
    end
  end
endmodule

// File: rtl/dmaregs_top.sv
module dmaregs_top
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  parameter int AW     = 2 * DW,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int HA_W   = CH_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_cs,
  input  logic            host_we,
  input  logic            host_re,
  input  logic [HA_W-1:0] host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            step_valid,
  output logic            step_ready,
  input  logic [CH_W-1:0] step_ch,
  output logic            out_valid,
  output logic [AW-1:0]   out_addr,
  output logic            out_tc
);
  logic [NUM_CH-1:0][AW-1:0] base_addr_vec, cur_addr_vec, base_cnt_vec, cur_cnt_vec;
  logic [NUM_CH-1:0]         done_vec, auto_vec, dec_vec;
  logic [NUM_CH-1:0]         wr_addr_en, wr_cnt_en;
  logic                      host_wr, wr_hi, mode_we, mclr;
  logic [CH_W-1:0]           mode_ch;
  ch_mode_t                  mode_val;

  logic            step_ch_ok, step_fire;
  logic [AW-1:0]   sel_cur_addr, sel_cur_cnt, sel_base_addr, sel_base_cnt;
  logic            sel_auto, sel_dec, sel_done;
  logic [AW-1:0]   nxt_addr, nxt_cnt;
  logic            step_tc;

  dmaregs_host_if #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW), .CH_W(CH_W), .HA_W(HA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .cur_addr_vec(cur_addr_vec), .cur_cnt_vec(cur_cnt_vec), .done_vec(done_vec),
    .host_wr(host_wr), .wr_addr_en(wr_addr_en), .wr_cnt_en(wr_cnt_en), .wr_hi(wr_hi),
    .mode_we(mode_we), .mode_ch(mode_ch), .mode_val(mode_val), .mclr(mclr),
    .host_rdata(host_rdata)
  );

  assign step_ch_ok = (int'(step_ch) < NUM_CH);

  always_comb begin
    sel_cur_addr  = '0;
    sel_cur_cnt   = '0;
    sel_base_addr = '0;
    sel_base_cnt  = '0;
    sel_auto      = 1'b0;
    sel_dec       = 1'b0;
    sel_done      = 1'b1;
    if (step_ch_ok) begin
      sel_cur_addr  = cur_addr_vec[step_ch];
      sel_cur_cnt   = cur_cnt_vec[step_ch];
      sel_base_addr = base_addr_vec[step_ch];
      sel_base_cnt  = base_cnt_vec[step_ch];
      sel_auto      = auto_vec[step_ch];
      sel_dec       = dec_vec[step_ch];
      sel_done      = done_vec[step_ch];
    end
  end

  // host writes own the register file for the cycle; completed channels stall
  assign step_ready = ~host_wr & ~sel_done;
  assign step_fire  = step_valid & step_ready;

  dmaregs_stepper #(.AW(AW)) u_step (
    .cur_addr(sel_cur_addr), .cur_cnt(sel_cur_cnt),
    .base_addr(sel_base_addr), .base_cnt(sel_base_cnt),
    .dec(sel_dec), .auto_init(sel_auto),
    .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt), .tc(step_tc)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic     upd_en;
    ch_mode_t mode_q;
    assign upd_en = step_fire && (step_ch == CH_W'(g));

    dmaregs_chan #(.AW(AW), .DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_addr_en(wr_addr_en[g]), .wr_cnt_en(wr_cnt_en[g]), .wr_hi(wr_hi),
      .wdata(host_wdata),
      .upd_en(upd_en), .upd_addr(nxt_addr), .upd_cnt(nxt_cnt),
      .set_done(upd_en & step_tc & ~sel_auto),
      .clr_done(mclr | wr_addr_en[g] | wr_cnt_en[g]),
      .mode_we(mode_we && (mode_ch == CH_W'(g))), .mode_in(mode_val),
      .base_addr(base_addr_vec[g]), .cur_addr(cur_addr_vec[g]),
      .base_cnt(base_cnt_vec[g]), .cur_cnt(cur_cnt_vec[g]),
      .mode(mode_q), .done(done_vec[g])
    );
    assign auto_vec[g] = mode_q.auto_init;
    assign dec_vec[g]  = mode_q.dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_tc    <= 1'b0;
    end else begin
      out_valid <= step_fire;
      if (step_fire) begin
        out_addr <= sel_cur_addr;
        out_tc   <= step_tc;
      end
    end
  end
endmodule

// File: rtl/dmaregs_chk.sv
module dmaregs_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int CH_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      host_cs,
  input logic                      host_we,
  input logic                      step_valid,
  input logic                      step_ready,
  input logic                      step_fire,
  input logic [CH_W-1:0]           step_ch,
  input logic                      out_valid,
  input logic                      out_tc,
  input logic [AW-1:0]             sel_cur_addr,
  input logic [AW-1:0]             sel_cur_cnt,
  input logic                      sel_auto,
  input logic                      sel_dec,
  input logic [NUM_CH-1:0]         done_vec,
  input logic [NUM_CH-1:0][AW-1:0] cur_addr_vec
);
  assert_accept_gives_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> out_valid);
  assert_no_spurious_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> !out_valid);
  assert_host_write_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we) |-> !step_ready);
  assert_addr_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !sel_dec && (sel_cur_cnt != '0)) |=>
      cur_addr_vec[$past(step_ch)] == AW'($past(sel_cur_addr) + AW'(1)));
  assert_addr_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && sel_dec && (sel_cur_cnt != '0)) |=>
      cur_addr_vec[$past(step_ch)] == AW'($past(sel_cur_addr) - AW'(1)));
  assert_tc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (out_tc == $past(sel_cur_cnt == '0)));
  assert_stop_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !sel_auto && (sel_cur_cnt == '0) && !(host_cs && host_we)) |=>
      done_vec[$past(step_ch)]);
  assert_done_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> !done_vec[step_ch]);
endmodule

bind dmaregs_top dmaregs_chk #(.NUM_CH(NUM_CH), .AW(AW), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
  .step_valid(step_valid), .step_ready(step_ready), .step_fire(step_fire),
  .step_ch(step_ch), .out_valid(out_valid), .out_tc(out_tc),
  .sel_cur_addr(sel_cur_addr), .sel_cur_cnt(sel_cur_cnt),
  .sel_auto(sel_auto), .sel_dec(sel_dec),
  .done_vec(done_vec), .cur_addr_vec(cur_addr_vec)
);

// File: tb/tb_dmaregs_top.sv
module tb_dmaregs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 0, host_we = 0, host_re = 0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        step_valid = 0;
  logic        step_ready;
  logic [1:0]  step_ch = '0;
  logic        out_valid;
  logic [15:0] out_addr;
  logic        out_tc;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  dmaregs_top dut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .step_valid(step_valid), .step_ready(step_ready), .step_ch(step_ch),
    .out_valid(out_valid), .out_addr(out_addr), .out_tc(out_tc)
  );

  always #2 clk = ~clk;

  // reference state
  logic [15:0] m_base_a [4], m_cur_a [4], m_base_c [4], m_cur_c [4];
  logic [3:0]  m_auto, m_dec, m_done;
  logic        m_ptr;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] put_b(logic [15:0] old, logic hi, logic [7:0] b);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] a);
    logic [15:0] w;
    if (a < 8) begin
      w = a[0] ? m_cur_c[a[2:1]] : m_cur_a[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 8) return {4'b0, m_done};
    return 8'h00;
  endfunction

  task automatic model_write(logic [3:0] a, logic [7:0] d);
    if (a < 8) begin
      if (a[0]) begin
        m_base_c[a[2:1]] = put_b(m_base_c[a[2:1]], m_ptr, d);
        m_cur_c[a[2:1]]  = put_b(m_cur_c[a[2:1]], m_ptr, d);
      end else begin
        m_base_a[a[2:1]] = put_b(m_base_a[a[2:1]], m_ptr, d);
        m_cur_a[a[2:1]]  = put_b(m_cur_a[a[2:1]], m_ptr, d);
      end
      m_done[a[2:1]] = 1'b0;
      m_ptr = ~m_ptr;
    end else if (a == 8) begin
      m_auto[d[1:0]] = d[4];
      m_dec[d[1:0]]  = d[5];
    end else if (a == 9) begin
      m_ptr = 1'b0;
    end else if (a == 10) begin
      m_ptr = 1'b0;
      m_done = '0;
    end
  endtask

  task automatic host_write(logic [3:0] a, logic [7:0] d, bit with_step = 0, logic [1:0] ch = 0);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
    if (with_step) begin step_valid = 1; step_ch = ch; end
    #1;
    if (with_step) check("R10 ready during write", step_ready, 0);
    @(posedge clk); #1;
    host_cs = 0; host_we = 0; step_valid = 0;
    check("R10 no result after write cycle", out_valid, 0);
    model_write(a, d);
  endtask

  task automatic host_read(logic [3:0] a, string req = "R4");
    @(negedge clk);
    host_cs = 1; host_re = 1; host_addr = a;
    #1;
    check(req, host_rdata, exp_read(a));
    @(posedge clk); #1;
    host_cs = 0; host_re = 0;
    if (a < 8) m_ptr = ~m_ptr;
  endtask

  task automatic do_step(logic [1:0] ch, string req = "R9");
    bit acc, tc;
    @(negedge clk);
    step_valid = 1; step_ch = ch;
    #1;
    acc = !m_done[ch];
    check({req, " step_ready (R8)"}, step_ready, acc);
    @(posedge clk); #1;
    step_valid = 0;
    check({req, " out_valid"}, out_valid, acc);
    if (acc) begin
      tc = (m_cur_c[ch] == 0);
      check({req, " out_addr"}, out_addr, m_cur_a[ch]);
      check({req, " out_tc (R6)"}, out_tc, tc);
      if (tc && m_auto[ch]) begin
        m_cur_a[ch] = m_base_a[ch];
        m_cur_c[ch] = m_base_c[ch];
      end else begin
        m_cur_a[ch] = m_dec[ch] ? m_cur_a[ch] - 16'd1 : m_cur_a[ch] + 16'd1;
        m_cur_c[ch] = m_cur_c[ch] - 16'd1;
        if (tc) m_done[ch] = 1'b1;
      end
    end
  endtask

  task automatic prog16(logic [1:0] ch, bit is_cnt, logic [15:0] v);
    host_write(4'd9, 8'h00);
    host_write({1'b0, ch, is_cnt}, v[7:0]);
    host_write({1'b0, ch, is_cnt}, v[15:8]);
  endtask

  task automatic read16(logic [1:0] ch, bit is_cnt, string req);
    host_write(4'd9, 8'h00);
    host_read({1'b0, ch, is_cnt}, req);
    host_read({1'b0, ch, is_cnt}, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      m_base_a[i] = 0; m_cur_a[i] = 0; m_base_c[i] = 0; m_cur_c[i] = 0;
    end
    m_auto = 0; m_dec = 0; m_done = 0; m_ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 step_ready", step_ready, 1);
    host_read(4'd8, "R1 status");
    host_read(4'd0, "R1 ch0 addr lo");
    host_read(4'd0, "R1 ch0 addr hi");
    host_read(4'd7, "R1 ch3 count lo");

    // R2 byte loading both copies, R4 readback
    prog16(2'd1, 0, 16'h1234);
    read16(2'd1, 0, "R2 addr readback");
    // R3 pointer clear after a single byte
    host_write(4'd2, 8'hAA);
    host_write(4'd9, 8'hFF);
    host_write(4'd2, 8'h55);
    host_write(4'd2, 8'h66);
    read16(2'd1, 0, "R3 pointer clear");

    // R5 wrap up and down
    prog16(2'd2, 0, 16'hFFFF);
    prog16(2'd2, 1, 16'h0005);
    do_step(2'd2, "R5 inc");
    do_step(2'd2, "R5 inc wrapped");
    host_write(4'd8, 8'h23);   // ch3 decrement
    prog16(2'd3, 1, 16'h0004);
    do_step(2'd3, "R5 dec");
    do_step(2'd3, "R5 dec wrapped");

    // R6 / R8: count 2 gives three transfers, then stall
    host_write(4'd8, 8'h00);
    prog16(2'd0, 0, 16'h0100);
    prog16(2'd0, 1, 16'h0002);
    do_step(2'd0, "R6 first");
    do_step(2'd0, "R6 second");
    do_step(2'd0, "R6 third tc");
    do_step(2'd0, "R8 stalled");
    host_read(4'd8, "R8 status bit");
    read16(2'd0, 1, "R8 count wrapped");

    // R7 auto reload
    host_write(4'd8, 8'h11);
    prog16(2'd1, 0, 16'h4000);
    prog16(2'd1, 1, 16'h0001);
    do_step(2'd1, "R7 a");
    do_step(2'd1, "R7 tc");
    do_step(2'd1, "R7 after reload");
    read16(2'd1, 1, "R7 count reloaded");

    // R10 collision, R11 master clear
    host_write(4'd5, 8'h77, 1, 2'd2);
    host_write(4'd10, 8'h00);
    host_read(4'd8, "R11 status cleared");
    do_step(2'd0, "R11 channel runs again");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      int unsigned op;
      logic [1:0] ch;
      op = $urandom % 100;
      ch = 2'($urandom % 4);
      if (op < 50)       do_step(ch, "R9 random");
      else if (op < 62)  prog16(ch, 1, ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 6));
      else if (op < 68)  prog16(ch, 0, 16'($urandom));
      else if (op < 74)  host_write(4'd8, 8'($urandom) & 8'h33);
      else if (op < 86)  host_read(4'($urandom % 12), "R4 random");
      else if (op < 90)  host_write(4'($urandom % 8), 8'($urandom));
      else if (op < 94)  host_write(4'd9, 8'($urandom));
      else if (op < 96)  host_write(4'd10, 8'h00);
      else               host_write(4'($urandom % 11), 8'($urandom) & 8'h33, 1, ch);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule